// File: doc/BRIEF.md
# Receive Flow-Control Pause Timer Bank

This block sits on the receive side of an Ethernet MAC, behind the frame parser. The parser hands it decoded pause requests of two kinds. A link-level XOFF carries one 16-bit quanta value. A priority XOFF carries an 8-bit class-enable vector and eight 16-bit quanta values, one for each traffic class. The block keeps one link pause timer and eight per-class timers. Each pause output stays high while its timer is non-zero.

Timers are kept in cycles. A quanta of Q loads Q × 512, and a timer counts down only on cycles where the count-enable qualifier is high. The width of each output pulse therefore equals the requested pause length in qualified cycles. A configuration input selects whether a link pause must actually stop the transmit side, which the block shows on a separate hold output. When that input is clear, the link pause output is only an indication.

Top module: `fc_pause_timers`

## Requirements
- R1: A link request with non-zero quanta Q loads the link timer to Q×512. `link_pause_o` is high from the cycle after the request edge for exactly Q×512 qualified cycles, then goes low.
- R2: A class request loads timer i, for each i whose `prio_class_en[i]` is 1, from quanta bits [16i+15:16i] of `prio_quanta`. Bit i of `prio_pause_o` then behaves as in R1. One request may load several classes at once.
- R3: Class timers are independent. Requests that reach different classes at different times each start their own countdown, and no timer disturbs another.
- R4: A non-zero quanta that arrives while a timer is counting replaces the remaining count with the new Q×512.
- R5: A quanta of zero on the link request, or on an enabled class, clears that timer. Its output is low in the cycle after the request edge.
- R6: A class whose enable bit is 0 in a request keeps its timer, whatever its quanta slice holds.
- R7: Timers decrement only on edges where `cnt_en` is 1. When `cnt_en` is 0, timers and outputs hold their values.
- R8: A timer that reaches zero stays at zero without wrapping. Each timer is 25 bits wide, which is enough for 65535×512.
- R9: `link_tx_hold_o` equals `link_pause_o` when `cfg_link_stop` is 1, and is 0 when `cfg_link_stop` is 0.
- R10: While `rst_n` is sampled low at a clock edge, all timers clear and all pause and hold outputs are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Valid qualifier; timers decrement only when high |
| cfg_link_stop | input | 1 | 1: a link pause must stop transmit; 0: indication only |
| link_req | input | 1 | One-cycle strobe: link XOFF/XON decoded |
| link_quanta | input | 16 | Quanta of the link request |
| prio_req | input | 1 | One-cycle strobe: class request decoded |
| prio_class_en | input | 8 | Class-enable vector of the class request |
| prio_quanta | input | 128 | Eight 16-bit quanta; class i at bits [16i+15:16i] |
| link_pause_o | output | 1 | Link timer non-zero |
| link_tx_hold_o | output | 1 | Transmit must stop for link pause |
| prio_pause_o | output | 8 | Bit i high while class timer i is non-zero |

## Verification
The assertions assume that the request strobes and quanta inputs are stable and defined at each sampling edge, and that a request strobe lasts exactly one cycle for each decoded frame. The stimulus drives every input just after a falling edge, holds each strobe for a single cycle, and keeps every quanta used in a countdown small (one or two quanta). A large quanta is used only to show that it is held before an XON clears it. Gaps in `cnt_en` are inserted only at known cycles, so the expected release cycle of each output can be computed from the request cycle plus the stalled edges.

// File: rtl/fc_timer_pkg.sv
// Package: shared sizing constants for the receive pause timer bank.
// Assumes quanta are 16-bit values and one quanta is 2**QUANTA_SHIFT cycles.
package fc_timer_pkg;
    localparam int NUM_PRIO     = 8;
    localparam int QUANTA_W     = 16;
    localparam int QUANTA_SHIFT = 9;   // 512 cycles per quanta
endpackage

// File: rtl/fc_req_decode.sv
// Module: fc_req_decode
// Turns the link and class request strobes into one load strobe and one
// quanta value per timer. Slot 0 is the link timer; slot i+1 is class i.
// Assumes at most one strobe of each kind per cycle; both kinds may coincide.
module fc_req_decode #(
    parameter int NUM_PRIO = 8,
    parameter int QUANTA_W = 16
) (
    input  logic                         link_req,
    input  logic [QUANTA_W-1:0]          link_quanta,
    input  logic                         prio_req,
    input  logic [NUM_PRIO-1:0]          prio_class_en,
    input  logic [NUM_PRIO*QUANTA_W-1:0] prio_quanta,
    output logic [NUM_PRIO:0]            slot_load,
    output logic [QUANTA_W-1:0]          slot_quanta [NUM_PRIO+1]
);
    // Link slot: load on every link strobe.
    always_comb begin
        slot_load[0]   = link_req;
        slot_quanta[0] = link_quanta;
    end

    // Class slots: a class loads only when its enable bit is set (R6).
    for (genvar i = 0; i < NUM_PRIO; i++) begin : g_cls
        always_comb begin
            slot_load[i+1]   = prio_req && prio_class_en[i];
            slot_quanta[i+1] = prio_quanta[i*QUANTA_W +: QUANTA_W];
        end
    end
endmodule

// File: rtl/fc_quanta_timer.sv
// Module: fc_quanta_timer
// One pause countdown in cycles. A load replaces the count with
// quanta << SHIFT (zero quanta clears it). Otherwise the count decrements on
// qualified cycles and saturates at zero. active is high while the count is
// non-zero.
// Assumes load is a single-cycle strobe.
module fc_quanta_timer #(
    parameter int QUANTA_W = 16,
    parameter int SHIFT    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_en,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_quanta,
    output logic                active
);
    localparam int CW = QUANTA_W + SHIFT;
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] count;

    // Countdown register: load wins, else decrement on valid non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= {load_quanta, {SHIFT{1'b0}}};
        else if (cnt_en && (count != '0))
            count <= count - ONE;
    end

    // Output: pause is asserted while time remains.
    assign active = (count != '0);

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == {$past(load_quanta), {SHIFT{1'b0}}}); // R4
    AST_XON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_quanta == '0) |=> !active); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !cnt_en) |=> $stable(count)); // R7
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_en && active) |=> count == $past(count) - ONE); // R1
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !active) |=> !active); // R8
endmodule

// File: rtl/fc_pause_timers.sv
// Module: fc_pause_timers (top)
// Receive flow-control timer bank: one link pause timer and NUM_PRIO class
// timers, fed by decoded XOFF/XON requests. It drives the pause levels and a
// transmit-hold level toward the transmit client.
// Assumes requests arrive already decoded from valid pause frames.
module fc_pause_timers
    import fc_timer_pkg::*;
#(
    parameter int N_PRIO  = NUM_PRIO,
    parameter int Q_W     = QUANTA_W,
    parameter int Q_SHIFT = QUANTA_SHIFT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cnt_en,
    input  logic                     cfg_link_stop,
    input  logic                     link_req,
    input  logic [Q_W-1:0]           link_quanta,
    input  logic                     prio_req,
    input  logic [N_PRIO-1:0]        prio_class_en,
    input  logic [N_PRIO*Q_W-1:0]    prio_quanta,
    output logic                     link_pause_o,
    output logic                     link_tx_hold_o,
    output logic [N_PRIO-1:0]        prio_pause_o
);
    localparam int N_SLOT = N_PRIO + 1;

    logic [N_SLOT-1:0] slot_load;
    logic [Q_W-1:0]    slot_quanta [N_SLOT];
    logic [N_SLOT-1:0] slot_active;

    fc_req_decode #(.NUM_PRIO(N_PRIO), .QUANTA_W(Q_W)) u_decode (
        .link_req     (link_req),
        .link_quanta  (link_quanta),
        .prio_req     (prio_req),
        .prio_class_en(prio_class_en),
        .prio_quanta  (prio_quanta),
        .slot_load    (slot_load),
        .slot_quanta  (slot_quanta)
    );

    for (genvar s = 0; s < N_SLOT; s++) begin : g_tmr
        fc_quanta_timer #(.QUANTA_W(Q_W), .SHIFT(Q_SHIFT)) u_tmr (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_en     (cnt_en),
            .load       (slot_load[s]),
            .load_quanta(slot_quanta[s]),
            .active     (slot_active[s])
        );
    end

    // Output mapping: slot 0 is the link timer, the rest are classes.
    always_comb begin
        link_pause_o   = slot_active[0];
        prio_pause_o   = slot_active[N_SLOT-1:1];
        link_tx_hold_o = cfg_link_stop && slot_active[0];
    end

    AST_CLASS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_req && !prio_req && !cnt_en) |=> $stable(prio_pause_o)); // R6
    AST_XON_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (link_req && link_quanta == '0) |=> !link_pause_o && !link_tx_hold_o); // R5
endmodule

// File: tb/fc_pause_timers_tb_top.sv
module fc_pause_timers_tb_top;
    localparam int NP = 8;
    localparam int QW = 16;
    localparam int QC = 512;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b1;
    logic cfg_link_stop = 1'b1;
    logic link_req = 1'b0;
    logic [QW-1:0] link_quanta = '0;
    logic prio_req = 1'b0;
    logic [NP-1:0] prio_class_en = '0;
    logic [NP*QW-1:0] prio_quanta = '0;
    logic link_pause_o, link_tx_hold_o;
    logic [NP-1:0] prio_pause_o;

    always #4 clk = ~clk; // 125 MHz

    fc_pause_timers dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cfg_link_stop(cfg_link_stop),
        .link_req(link_req), .link_quanta(link_quanta), .prio_req(prio_req),
        .prio_class_en(prio_class_en), .prio_quanta(prio_quanta),
        .link_pause_o(link_pause_o), .link_tx_hold_o(link_tx_hold_o),
        .prio_pause_o(prio_pause_o)
    );

    // kind: 0 link pause, 1 class vector (masked), 2 hold
    typedef struct {
        int          cyc;
        int          kind;
        logic [7:0]  exp;
        logic [7:0]  mask;
        string       tag;
    } item_t;

    item_t sb [$];
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int c, input int k, input logic [7:0] e,
                             input logic [7:0] m, input string t);
        item_t it;
        it.cyc = c; it.kind = k; it.exp = e; it.mask = m; it.tag = t;
        sb.push_back(it);
    endtask

    // Monitor: compare every item due in this cycle, away from the rising edge.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                logic [7:0] act;
                case (sb[i].kind)
                    0: act = {7'd0, link_pause_o};
                    1: act = prio_pause_o;
                    default: act = {7'd0, link_tx_hold_o};
                endcase
                act = act & sb[i].mask;
                checks++;
                if (act !== (sb[i].exp & sb[i].mask)) begin
                    fails++;
                    $display("FAIL %s cyc=%0d kind=%0d actual=%h expected=%h",
                             sb[i].tag, cyc, sb[i].kind, act, sb[i].exp & sb[i].mask);
                end
                sb.delete(i);
            end
        end
    end

    // Drivers: called at a falling edge; the request is captured at edge cyc+1.
    task automatic send_link(input logic [QW-1:0] q);
        link_req = 1'b1; link_quanta = q;
        @(negedge clk);
        link_req = 1'b0; link_quanta = '0;
    endtask

    task automatic send_prio(input logic [NP-1:0] en, input logic [NP*QW-1:0] qv);
        prio_req = 1'b1; prio_class_en = en; prio_quanta = qv;
        @(negedge clk);
        prio_req = 1'b0; prio_class_en = '0; prio_quanta = '0;
    endtask

    function automatic logic [NP*QW-1:0] qslot(input int i, input logic [QW-1:0] v);
        logic [NP*QW-1:0] r = '0;
        r[i*QW +: QW] = v;
        return r;
    endfunction

    task automatic idle_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        int e, e2;
        repeat (3) @(negedge clk);
        // R10: reset state
        expect_at(cyc + 1, 0, 8'h00, 8'h01, "R10 reset link");
        expect_at(cyc + 1, 1, 8'h00, 8'hFF, "R10 reset class");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R9: link XOFF of one quanta, hold follows with cfg set
        e = cyc + 1;
        expect_at(e, 0, 8'h01, 8'h01, "R1 link high at start");
        expect_at(e, 2, 8'h01, 8'h01, "R9 hold with cfg set");
        expect_at(e + QC - 1, 0, 8'h01, 8'h01, "R1 link high last cycle");
        expect_at(e + QC, 0, 8'h00, 8'h01, "R1 link low after 512");
        expect_at(e + QC + 40, 0, 8'h00, 8'h01, "R8 link stays low");
        send_link(16'd1);
        idle_until(e + QC + 45);

        // R9: cfg clear gives indication only
        cfg_link_stop = 1'b0;
        e = cyc + 1;
        expect_at(e + 5, 0, 8'h01, 8'h01, "R9 link pause shown");
        expect_at(e + 5, 2, 8'h00, 8'h01, "R9 no hold when cfg clear");
        send_link(16'd1);
        idle_until(e + QC + 2);
        cfg_link_stop = 1'b1;

        // R2: one request loads classes 1 and 2 with 1 and 2 quanta
        e = cyc + 1;
        expect_at(e, 1, 8'h06, 8'hFF, "R2 two classes set");
        expect_at(e + QC, 1, 8'h04, 8'hFF, "R2 class1 expired first");
        expect_at(e + 2*QC - 1, 1, 8'h04, 8'hFF, "R2 class2 still on");
        expect_at(e + 2*QC, 1, 8'h00, 8'hFF, "R2 class2 expired");
        send_prio(8'h06, qslot(1, 16'd1) | qslot(2, 16'd2));
        idle_until(e + 2*QC + 2);

        // R3: class 0 then class 6 at different times
        e = cyc + 1;
        e2 = e + 100;
        expect_at(e + 50, 1, 8'h01, 8'hFF, "R3 class0 alone");
        expect_at(e + QC, 1, 8'h40, 8'hFF, "R3 class0 done class6 on");
        expect_at(e2 + QC - 1, 1, 8'h40, 8'hFF, "R3 class6 last cycle");
        expect_at(e2 + QC, 1, 8'h00, 8'hFF, "R3 class6 done");
        send_prio(8'h01, qslot(0, 16'd1));
        idle_until(e2 - 1);
        send_prio(8'h40, qslot(6, 16'd1));
        idle_until(e2 + QC + 2);

        // R4: reload while counting replaces the remaining count
        e = cyc + 1;
        e2 = e + 300;
        expect_at(e + QC, 0, 8'h01, 8'h01, "R4 reload extends pause");
        expect_at(e2 + QC - 1, 0, 8'h01, 8'h01, "R4 reloaded last cycle");
        expect_at(e2 + QC, 0, 8'h00, 8'h01, "R4 reloaded expiry");
        send_link(16'd1);
        idle_until(e2 - 1);
        send_link(16'd1);
        idle_until(e2 + QC + 2);

        // R5/R8: large quanta held, then XON clears at once
        e = cyc + 1;
        e2 = e + 20;
        expect_at(e + 10, 0, 8'h01, 8'h01, "R8 max quanta held");
        expect_at(e2, 0, 8'h00, 8'h01, "R5 link XON clears");
        expect_at(e2, 2, 8'h00, 8'h01, "R5 hold drops on XON");
        send_link(16'hFFFF);
        idle_until(e2 - 1);
        send_link(16'd0);
        idle_until(e2 + 3);

        // R5/R6: XON on class1 only; class0 slot zero but disabled keeps running
        e = cyc + 1;
        e2 = e + 100;
        expect_at(e2 - 1, 1, 8'h03, 8'hFF, "R6 both classes on");
        expect_at(e2, 1, 8'h01, 8'hFF, "R5 class1 XON, R6 class0 kept");
        expect_at(e + QC - 1, 1, 8'h01, 8'hFF, "R6 class0 full length");
        expect_at(e + QC, 1, 8'h00, 8'hFF, "R6 class0 expiry");
        send_prio(8'h03, qslot(0, 16'd1) | qslot(1, 16'd1));
        idle_until(e2 - 1);
        send_prio(8'h02, '0);
        idle_until(e + QC + 2);

        // R7: 100 stalled edges stretch the pause
        e = cyc + 1;
        expect_at(e + 60, 0, 8'h01, 8'h01, "R7 held during stall");
        expect_at(e + QC + 99, 0, 8'h01, 8'h01, "R7 still on past nominal");
        expect_at(e + QC + 100, 0, 8'h00, 8'h01, "R7 expiry after stall");
        send_link(16'd1);
        cnt_en = 1'b0;
        idle_until(e + 100);
        cnt_en = 1'b1;
        idle_until(e + QC + 102);

        // R10: reset in the middle of active pauses
        send_link(16'd2);
        send_prio(8'hFF, {NP{16'd2}});
        idle_until(cyc + 10);
        e = cyc + 1;
        expect_at(e, 0, 8'h00, 8'h01, "R10 link cleared by reset");
        expect_at(e, 1, 8'h00, 8'hFF, "R10 classes cleared by reset");
        expect_at(e, 2, 8'h00, 8'h01, "R10 hold cleared by reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        expect_at(e + 5, 1, 8'h00, 8'hFF, "R10 stays clear after reset");
        idle_until(e + 7);

        while (sb.size() != 0) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule